// File: doc/BRIEF.md
# Burst-Refilled Display Line FIFO

This block sits between a memory-fetch port and the pixel formatter of a display controller. It stores 32-bit frame words in 28 entries, arranged as a 12-entry lower bank followed by a 16-entry upper bank. The read and write pointers advance through both banks and wrap at 28.

The block asks for its own refills. While no fetch is outstanding and at least four entries are free, it raises a request. The request holds until it is granted. The fetch side then delivers a burst of four words. The formatter pops words in order and sees the oldest word on the read port. A pop that finds the FIFO empty sets a sticky underrun flag. A flush input clears the contents at frame start and abandons any fetch in flight.

Top module: `line_fifo`

## Requirements
- R1: Words leave in the order they were written. Whenever `empty_o` is low, `rd_data_o` shows the oldest stored word, and a pop removes it at the next clock edge. `empty_o` is high exactly when no word is stored.
- R2: The FIFO holds 28 words: 12 in the lower bank and 16 in the upper bank. Both pointers wrap from entry 27 to entry 0, and order is kept across any number of wraps.
- R3: `req_o` is high only while at most 24 words are stored. A full burst therefore always fits, and occupancy never goes above 28.
- R4: Once raised, `req_o` stays high until a cycle in which `gnt_i` is high, and it is low on the next cycle. No new request is raised until the granted burst has ended.
- R5: After a grant, words with `wr_valid_i` high are stored. The burst ends with its fourth stored word, or earlier with a stored word that has `wr_last_i` high. `wr_valid_i` has no effect while no burst is granted, and `gnt_i` has no effect while `req_o` is low.
- R6: A pop while `empty_o` is high sets `underrun_o` at the next edge and changes nothing else. `underrun_o` stays set until a cycle with `clr_underrun_i` high and no such pop. If both happen in the same cycle, the set wins.
- R7: A pop and a stored write in the same cycle both take effect, and occupancy is unchanged.
- R8: When `flush_i` is high, on the next cycle the FIFO is empty and `req_o` is low. Any pop or write in the flush cycle is discarded, and writes are ignored until a new grant. The underrun flag is not affected by flush.
- R9: After reset, `empty_o` is high and `req_o` and `underrun_o` are low. When no fetch is outstanding and at most 24 words are stored at a clock edge, `req_o` is high after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear contents and cancel the fetch |
| req_o | output | 1 | Refill request for one burst |
| gnt_i | input | 1 | Grant of the pending request |
| wr_valid_i | input | 1 | Burst word valid |
| wr_data_i | input | 32 | Burst word |
| wr_last_i | input | 1 | Marks the final word of a burst |
| pop_i | input | 1 | Formatter consumes the head word |
| rd_data_o | output | 32 | Head word (oldest stored) |
| empty_o | output | 1 | No word stored |
| underrun_o | output | 1 | Sticky flag: a pop found the FIFO empty |
| clr_underrun_i | input | 1 | Clears the underrun flag |

## Verification
A formatter pop and a burst write can land in the same cycle. That cycle can also bring a flush, a clear of the underrun flag or a grant. The bench drives grant, write valid, last, pop, flush and clear from independent pseudo-random streams across phases with different pop rates and write gaps. This makes simultaneous pop and write, pop on empty together with a clear, and flush in the middle of a burst occur many times. After each edge it compares every output with a queue model computed from the requirements. Any lost, duplicated or reordered word, or a wrong request edge, shows up as a miscompare.

// File: rtl/line_fifo_pkg.sv
package line_fifo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/lf_ptr.sv
module lf_ptr #(
  parameter int DEPTH = 28,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (inc_i) ptr_o <= (ptr_o == PTR_W'(DEPTH - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/lf_store.sv
module lf_store #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 28,
  parameter int LOW_DEPTH = 12,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam bit SPLIT = (LOW_DEPTH > 0) && (LOW_DEPTH < DEPTH);

  if (SPLIT) begin : g_split
    localparam int HI_DEPTH = DEPTH - LOW_DEPTH;
    localparam int LO_W = (LOW_DEPTH > 1) ? $clog2(LOW_DEPTH) : 1;
    localparam int HI_W = (HI_DEPTH > 1) ? $clog2(HI_DEPTH) : 1;
    logic [DATA_W-1:0] lo_mem [LOW_DEPTH];
    logic [DATA_W-1:0] hi_mem [HI_DEPTH];
    logic [PTR_W-1:0]  w_hi, r_hi;
    logic              w_in_lo, r_in_lo;

    assign w_in_lo = waddr_i < PTR_W'(LOW_DEPTH);
    assign r_in_lo = raddr_i < PTR_W'(LOW_DEPTH);
    assign w_hi    = waddr_i - PTR_W'(LOW_DEPTH);
    assign r_hi    = raddr_i - PTR_W'(LOW_DEPTH);

    always_ff @(posedge clk_i) begin
      if (we_i && w_in_lo)  lo_mem[waddr_i[LO_W-1:0]] <= wdata_i;
      if (we_i && !w_in_lo) hi_mem[w_hi[HI_W-1:0]]    <= wdata_i;
    end

    assign rdata_o = r_in_lo ? lo_mem[raddr_i[LO_W-1:0]] : hi_mem[r_hi[HI_W-1:0]];
  end else begin : g_flat
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
    end
    assign rdata_o = mem[raddr_i];
  end
endmodule

// File: rtl/lf_fetch.sv
module lf_fetch
  import line_fifo_pkg::*;
#(
  parameter int BURST = 4,
  localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic room_i,
  input  logic gnt_i,
  input  logic wr_valid_i,
  input  logic wr_last_i,
  output logic req_o,
  output logic wr_en_o
);
  fetch_state_e      state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              burst_done;

  assign req_o      = (state_q == ST_REQ);
  assign wr_en_o    = (state_q == ST_BURST) && wr_valid_i && !flush_i;
  assign burst_done = wr_en_o && (wr_last_i || beat_q == BEAT_W'(BURST - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else if (flush_i) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (room_i) state_q <= ST_REQ;
        ST_REQ:   if (gnt_i)  state_q <= ST_BURST;
        ST_BURST: begin
          if (burst_done) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
          end else if (wr_en_o) begin
            beat_q  <= beat_q + 1'b1;
          end
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_fifo.sv
module line_fifo #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 28,
  parameter int LOW_DEPTH = 12,
  parameter int BURST     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  output logic              req_o,
  input  logic              gnt_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              underrun_o,
  input  logic              clr_underrun_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_en, pop_en, room;

  assign empty_o = (cnt_q == '0);
  assign pop_en  = pop_i && !empty_o && !flush_i;
  assign room    = (cnt_q <= CNT_W'(DEPTH - BURST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else if (wr_en && !pop_en) cnt_q <= cnt_q + 1'b1;
    else if (!wr_en && pop_en) cnt_q <= cnt_q - 1'b1;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   underrun_o <= 1'b0;
    else if (pop_i && empty_o)     underrun_o <= 1'b1;
    else if (clr_underrun_i)       underrun_o <= 1'b0;
  end

  lf_fetch #(.BURST(BURST)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .room_i     (room),
    .gnt_i      (gnt_i),
    .wr_valid_i (wr_valid_i),
    .wr_last_i  (wr_last_i),
    .req_o      (req_o),
    .wr_en_o    (wr_en)
  );

  lf_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flush_i), .inc_i (wr_en), .ptr_o (wr_ptr)
  );

  lf_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flush_i), .inc_i (pop_en), .ptr_o (rd_ptr)
  );

  lf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LOW_DEPTH(LOW_DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/line_fifo_chk.sv
module line_fifo_chk #(
  parameter int DEPTH = 28,
  parameter int BURST = 4,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             gnt_i,
  input logic             pop_i,
  input logic             clr_underrun_i,
  input logic             req_o,
  input logic             empty_o,
  input logic             underrun_o,
  input logic [CNT_W-1:0] cnt_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH)); // R3
  AST_REQ_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cnt_i <= CNT_W'(DEPTH - BURST)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i && !flush_i |=> req_o); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> !req_o); // R4
  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o |=> underrun_o); // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !clr_underrun_i |=> underrun_o); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && !req_o); // R8
endmodule

bind line_fifo line_fifo_chk #(.DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .gnt_i          (gnt_i),
  .pop_i          (pop_i),
  .clr_underrun_i (clr_underrun_i),
  .req_o          (req_o),
  .empty_o        (empty_o),
  .underrun_o     (underrun_o),
  .cnt_i          (cnt_q)
);

// File: tb/line_fifo_bench.sv
module line_fifo_bench;
  localparam int DW = 32, DEPTH = 28, BURST = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          flush, gnt, wv, wl, pop, clr;
  logic [DW-1:0] wd;
  logic          req, empty, unf;
  logic [DW-1:0] rdata;

  line_fifo u_line_fifo (
    .clk_i (clk), .rst_ni (rst_ni), .flush_i (flush), .req_o (req), .gnt_i (gnt),
    .wr_valid_i (wv), .wr_data_i (wd), .wr_last_i (wl), .pop_i (pop),
    .rd_data_o (rdata), .empty_o (empty), .underrun_o (unf), .clr_underrun_i (clr)
  );

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] m_q[$];
  int m_state = 0, m_beat = 0;
  bit m_unf = 1'b0;
  bit first = 1'b0, both = 1'b0;
  logic [31:0] rng = 32'h2545_f491;
  logic [31:0] seq = 32'h1000_0000;
  bit done = 1'b0;

  function automatic logic [31:0] rnd_next(logic [31:0] x);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int sz = m_q.size();
    chk(empty == (sz == 0), "R1 empty", 32'(empty), 32'(sz == 0));
    chk(req == (m_state == 1), first ? "R9 req" : "R4 req", 32'(req), 32'(m_state == 1));
    chk(unf == m_unf, "R6 underrun", 32'(unf), 32'(m_unf));
    chk(!(req && sz > DEPTH - BURST), "R3 room", 32'(sz), DEPTH - BURST);
    if (sz > 0) chk(rdata == m_q[0], both ? "R7 head" : "R2 head", rdata, m_q[0]);
  endtask

  task automatic step();
    int  sz = m_q.size();
    bit  we = (m_state == 2) && wv && !flush;
    bit  pe = pop && sz > 0 && !flush;
    @(posedge clk);
    both = we && pe;
    if (pop && sz == 0) m_unf = 1'b1;
    else if (clr)       m_unf = 1'b0;
    if (flush) begin
      m_q.delete(); m_state = 0; m_beat = 0;
    end else begin
      if (pe) void'(m_q.pop_front());
      if (we) m_q.push_back(wd);
      case (m_state)
        0: if (sz <= DEPTH - BURST) m_state = 1;
        1: if (gnt) m_state = 2;
        default: if (we) begin
          if (wl || m_beat == BURST - 1) begin m_state = 0; m_beat = 0; end
          else m_beat++;
        end
      endcase
    end
    @(negedge clk);
    compare();
    first = 1'b0;
  endtask

  task automatic run(int n, int pop_pct, int flush_pm, int gap_pct, int last_mod);
    for (int i = 0; i < n; i++) begin
      rng   = rnd_next(rng);
      gnt   = (rng % 100) < 60;
      wv    = ((rng >> 8) % 100) >= 32'(gap_pct);
      wd    = seq; seq = seq + 1;
      wl    = ((rng >> 16) % 32'(last_mod)) == 0;
      pop   = ((rng >> 20) % 100) < 32'(pop_pct);
      flush = ((rng >> 4) % 1000) < 32'(flush_pm);
      clr   = ((rng >> 26) % 16) == 0;
      step();
    end
  endtask

  initial begin
    flush = 0; gnt = 0; wv = 0; wl = 0; pop = 0; clr = 0; wd = '0;
    repeat (3) @(negedge clk);
    chk(empty && !req && !unf, "R9 reset", {29'd0, empty, req, unf}, 32'h4);
    rst_ni = 1'b1;
    first  = 1'b1;
    step();                               // R9: request rises at first edge
    run(300, 0, 0, 0, 1000);              // fill: R3 stop at 28
    chk(m_q.size() == DEPTH && !empty && !req, "R3 full", 32'(m_q.size()), DEPTH);
    pop = 1; clr = 1; gnt = 0; wv = 0; flush = 0;
    run(0, 0, 0, 0, 1);
    run(2000, 30, 2, 20, 1000);           // R5 writes outside burst, R7
    run(2000, 70, 2, 20, 6);              // R5 early last
    run(2000, 95, 6, 50, 1000);           // R6 underrun, R8 flush
    run(2000, 50, 0, 0, 1000);            // R2 steady wrap
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule